// File: doc/BRIEF.md
# Ring Buffer Address and Status Tracker

This block keeps the three pointers of a circular buffer that holds compressed audio. The write pointer moves once for each word the encoder stores. The read pointer moves once for each word the decoder fetches. The third pointer marks the end of the data the host has confirmed as good. Each pointer counts in units of 256 bits. On every falling edge of the block clock, the current write pointer is captured as a candidate. A host confirm strobe then commits that candidate as the valid end.

From these pointers the block derives three things:
- the residual amount of confirmed data, in units of 256 bits;
- an empty flag, which pauses reading and requests a mute while the memory system is on;
- two overflow flags. One follows the write-stop command. The other is a one-shot that the host clears by reading status.

The buffer size follows a two-bit memory selection. A guard area of a few kbit in front of the read pointer is counted as overflow.

Top module: `rb_track`

## Requirements
- R1: After reset, residual is 0 and empty, ovf_state, ovf_once and mute_req are all 0. A first falling edge of blk_clk is only seen after the block has sampled blk_clk high.
- R2: When blk_clk is 1 in one cycle and 0 in the next, the write pointer of that second cycle (before any advance in it) is stored as the candidate. A commit strobe loads the valid pointer from the candidate held before that cycle.
- R3: residual = (valid pointer - read pointer) modulo the buffer size, in 256-bit units, 16 bits wide, so bit 15 weighs 8 Mbit. It is visible in the cycle after the pointer change.
- R4: empty is set when a taken read or a commit leaves the valid pointer equal to the read pointer. It is 0 whenever the two differ. Reset and the address clears never set it.
- R5: rd_go = sys_on & rd_en & (residual != 0). A rd_adv strobe moves the read pointer only while rd_go is 1. Reading therefore resumes by itself once new data is committed.
- R6: ovf_state is set by a write advance that brings (write - read) modulo size to size minus guard. It clears on wr_stop, wa_clr or ra_clr.
- R7: ovf_once is set by the same crossing. It clears on stat_rd even while the overflow persists, and on wa_clr or ra_clr.
- R8: mem_sel 0, 1, 2 and 3 give sizes of 4096, 16384, 32768 and 65536 units. The matching guards are 8, 16, 16 and 32 units (2, 4, 4 and 8 kbit).
- R9: A clear condition in the same cycle as a set condition wins for every flag.
- R10: mute_req is 1 exactly when sys_on is 1 and empty is 1.
- R11: wa_clr zeroes the write pointer, the candidate and the valid pointer. ra_clr zeroes the read pointer. Every advance wraps modulo the buffer size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_sel | input | 2 | Buffer size selection |
| sys_on | input | 1 | Memory system enabled |
| rd_en | input | 1 | Host read-enable setting (level) |
| wr_adv | input | 1 | Write pointer advance strobe |
| rd_adv | input | 1 | Read pointer advance request |
| wa_clr | input | 1 | Clear write, candidate and valid pointers |
| ra_clr | input | 1 | Clear read pointer |
| blk_clk | input | 1 | Block clock level |
| commit | input | 1 | Validity confirm strobe |
| wr_stop | input | 1 | Host stops writing |
| stat_rd | input | 1 | Status read strobe |
| residual | output | 16 | Confirmed data remaining, 256-bit units |
| empty | output | 1 | No confirmed data remains |
| ovf_state | output | 1 | Writer has entered the guard area |
| ovf_once | output | 1 | One-shot overflow indication |
| rd_go | output | 1 | Read advance allowed |
| mute_req | output | 1 | Audio mute request |

## Verification
A wrong read or valid pointer shows up in residual in the very next cycle. It also shows in rd_go, which gates every later read, so the error keeps growing.

A wrong write pointer stays hidden until a block-clock edge and a commit bring it into residual. It can also surface when the overflow crossing arrives one write early or late. Long write runs at each buffer size therefore pin the crossing to the exact write.

Stray flag state shows in the cycle after the event. Two cases expose it: a status read issued in the same cycle as the crossing, and clears issued on an empty buffer.

// File: rtl/rb_pkg.sv
package rb_pkg;
    typedef enum logic [1:0] {
        MEM_SMALL = 2'd0,
        MEM_MID   = 2'd1,
        MEM_PAIR  = 2'd2,
        MEM_LARGE = 2'd3
    } mem_kind_e;

    // log2 of the buffer span in pointer units
    function automatic int unsigned span_log2(input mem_kind_e k, input int unsigned aw);
        case (k)
            MEM_SMALL: return aw - 4;
            MEM_MID:   return aw - 2;
            MEM_PAIR:  return aw - 1;
            default:   return aw;
        endcase
    endfunction

    // log2 of the guard area ahead of the read pointer
    function automatic int unsigned guard_log2(input mem_kind_e k, input int unsigned aw);
        case (k)
            MEM_SMALL:         return aw - 13;
            MEM_MID, MEM_PAIR: return aw - 12;
            default:           return aw - 11;
        endcase
    endfunction
endpackage

// File: rtl/rb_fall_detect.sv
module rb_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    assign fall = lvl_q & ~lvl;
endmodule

// File: rtl/rb_mod_dist.sv
module rb_mod_dist #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic [AW-1:0] mask,
    output logic [AW-1:0] d
);
    always_comb begin
        d = (a - b) & mask;
    end
endmodule

// File: rtl/rb_flags.sv
module rb_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic wr_stop,
    input  logic stat_rd,
    input  logic hit,
    input  logic ev,
    input  logic eq_next,
    output logic empty,
    output logic ovf_state,
    output logic ovf_once
);
    typedef struct packed {
        logic empty;
        logic ovs;
        logic ovo;
    } fl_t;

    fl_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (clr) begin
            fl_d = '0;
        end else begin
            if (wr_stop)  fl_d.ovs = 1'b0;
            else if (hit) fl_d.ovs = 1'b1;
            if (stat_rd)  fl_d.ovo = 1'b0;
            else if (hit) fl_d.ovo = 1'b1;
            if (!eq_next) fl_d.empty = 1'b0;
            else if (ev)  fl_d.empty = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign empty     = fl_q.empty;
    assign ovf_state = fl_q.ovs;
    assign ovf_once  = fl_q.ovo;
endmodule

// File: rtl/rb_track.sv
module rb_track #(
    parameter int ADDR_W = 16,
    parameter int RES_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mem_sel,
    input  logic             sys_on,
    input  logic             rd_en,
    input  logic             wr_adv,
    input  logic             rd_adv,
    input  logic             wa_clr,
    input  logic             ra_clr,
    input  logic             blk_clk,
    input  logic             commit,
    input  logic             wr_stop,
    input  logic             stat_rd,
    output logic [RES_W-1:0] residual,
    output logic             empty,
    output logic             ovf_state,
    output logic             ovf_once,
    output logic             rd_go,
    output logic             mute_req
);
    import rb_pkg::*;

    localparam int NDIST = 3;

    typedef struct packed {
        logic [ADDR_W-1:0] wa;
        logic [ADDR_W-1:0] ra;
        logic [ADDR_W-1:0] vwa;
        logic [ADDR_W-1:0] cand;
    } ptr_t;

    ptr_t p_d, p_q;

    logic [ADDR_W-1:0] mask, rsv, limit;
    logic              blk_fall, rd_take, hit, ev;
    logic [ADDR_W-1:0] da [NDIST];
    logic [ADDR_W-1:0] db [NDIST];
    logic [ADDR_W-1:0] dd [NDIST];

    always_comb begin
        mask  = {ADDR_W{1'b1}} >> (ADDR_W - span_log2(mem_kind_e'(mem_sel), ADDR_W));
        rsv   = ADDR_W'(1) << guard_log2(mem_kind_e'(mem_sel), ADDR_W);
        limit = mask - rsv + ADDR_W'(1);
    end

    rb_fall_detect u_fall (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (blk_clk),
        .fall (blk_fall)
    );

    // 0: confirmed data, 1: occupancy after update, 2: next confirmed data
    assign da[0] = p_q.vwa;
    assign db[0] = p_q.ra;
    assign da[1] = p_d.wa;
    assign db[1] = p_d.ra;
    assign da[2] = p_d.vwa;
    assign db[2] = p_d.ra;

    for (genvar gi = 0; gi < NDIST; gi++) begin : g_dist
        rb_mod_dist #(.AW(ADDR_W)) u_dist (
            .a   (da[gi]),
            .b   (db[gi]),
            .mask(mask),
            .d   (dd[gi])
        );
    end

    always_comb begin
        rd_go   = sys_on & rd_en & (dd[0] != '0);
        rd_take = rd_adv & rd_go;
        p_d     = p_q;
        if (wr_adv)   p_d.wa   = (p_q.wa + ADDR_W'(1)) & mask;
        if (rd_take)  p_d.ra   = (p_q.ra + ADDR_W'(1)) & mask;
        if (blk_fall) p_d.cand = p_q.wa & mask;
        if (commit)   p_d.vwa  = p_q.cand;
        if (wa_clr) begin
            p_d.wa   = '0;
            p_d.cand = '0;
            p_d.vwa  = '0;
        end
        if (ra_clr) p_d.ra = '0;
        hit = wr_adv & ~wa_clr & (dd[1] == limit);
        ev  = rd_take | commit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    rb_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wa_clr | ra_clr),
        .wr_stop  (wr_stop),
        .stat_rd  (stat_rd),
        .hit      (hit),
        .ev       (ev),
        .eq_next  (dd[2] == '0),
        .empty    (empty),
        .ovf_state(ovf_state),
        .ovf_once (ovf_once)
    );

    assign residual = RES_W'(dd[0]);
    assign mute_req = sys_on & empty;
endmodule

// File: rtl/rb_track_chk.sv
module rb_track_chk #(
    parameter int RES_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mem_sel,
    input logic             rd_adv,
    input logic             rd_go,
    input logic             commit,
    input logic             wa_clr,
    input logic             ra_clr,
    input logic             wr_stop,
    input logic             stat_rd,
    input logic [RES_W-1:0] residual,
    input logic             empty,
    input logic             ovf_state,
    input logic             ovf_once
);
    p_rd_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_adv && !rd_go && !commit && !wa_clr && !ra_clr)
        |=> ($stable(residual) || !$stable(mem_sel)));

    p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (residual == '0));

    p_once_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !ovf_once);

    p_state_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stop || wa_clr || ra_clr) |=> !ovf_state);

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_clr || ra_clr) |=> (!empty && !ovf_once && !ovf_state));
endmodule

bind rb_track rb_track_chk #(.RES_W(RES_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_sel  (mem_sel),
    .rd_adv   (rd_adv),
    .rd_go    (rd_go),
    .commit   (commit),
    .wa_clr   (wa_clr),
    .ra_clr   (ra_clr),
    .wr_stop  (wr_stop),
    .stat_rd  (stat_rd),
    .residual (residual),
    .empty    (empty),
    .ovf_state(ovf_state),
    .ovf_once (ovf_once)
);

// File: tb/rb_track_test.sv
module rb_track_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mem_sel = 2'd0;
    logic sys_on = 0, rd_en = 0, wr_adv = 0, rd_adv = 0, wa_clr = 0, ra_clr = 0;
    logic blk_clk = 0, commit = 0, wr_stop = 0, stat_rd = 0;
    logic [15:0] residual;
    logic empty, ovf_state, ovf_once, rd_go, mute_req;

    int checks = 0;
    int errors = 0;

    int unsigned m_wa, m_ra, m_vwa, m_cand;
    bit m_blk, m_empty, m_ovs, m_ovo;

    always #2 clk = ~clk;

    rb_track uut (
        .clk(clk), .rst_n(rst_n), .mem_sel(mem_sel), .sys_on(sys_on), .rd_en(rd_en),
        .wr_adv(wr_adv), .rd_adv(rd_adv), .wa_clr(wa_clr), .ra_clr(ra_clr),
        .blk_clk(blk_clk), .commit(commit), .wr_stop(wr_stop), .stat_rd(stat_rd),
        .residual(residual), .empty(empty), .ovf_state(ovf_state), .ovf_once(ovf_once),
        .rd_go(rd_go), .mute_req(mute_req)
    );

    function automatic int unsigned span(input logic [1:0] s);
        case (s)
            2'd0: return 4096;
            2'd1: return 16384;
            2'd2: return 32768;
            default: return 65536;
        endcase
    endfunction

    function automatic int unsigned guard(input logic [1:0] s);
        case (s)
            2'd0: return 8;
            2'd3: return 32;
            default: return 16;
        endcase
    endfunction

    function automatic int unsigned mdist(input int unsigned a, input int unsigned b);
        return (a - b) & (span(mem_sel) - 1);
    endfunction

    function automatic bit exp_go();
        return sys_on && rd_en && (m_vwa != m_ra);
    endfunction

    task automatic chk(input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int unsigned msk, wa_n, ra_n, vwa_n, cand_n;
        bit take, fall, clr, hit;
        msk    = span(mem_sel) - 1;
        take   = rd_adv && exp_go();
        fall   = m_blk && !blk_clk;
        wa_n   = wa_clr ? 0 : (wr_adv ? ((m_wa + 1) & msk) : m_wa);
        ra_n   = ra_clr ? 0 : (take ? ((m_ra + 1) & msk) : m_ra);
        cand_n = wa_clr ? 0 : (fall ? (m_wa & msk) : m_cand);
        vwa_n  = wa_clr ? 0 : (commit ? m_cand : m_vwa);
        clr    = wa_clr || ra_clr;
        hit    = wr_adv && !wa_clr && (mdist(wa_n, ra_n) == span(mem_sel) - guard(mem_sel));
        m_ovs  = (clr || wr_stop) ? 1'b0 : (hit ? 1'b1 : m_ovs);
        m_ovo  = (clr || stat_rd) ? 1'b0 : (hit ? 1'b1 : m_ovo);
        if (clr || (vwa_n != ra_n)) m_empty = 1'b0;
        else if (take || commit)    m_empty = 1'b1;
        m_wa = wa_n; m_ra = ra_n; m_vwa = vwa_n; m_cand = cand_n;
        m_blk = blk_clk;
    endtask

    task automatic compare_all();
        chk("R3 residual", residual, mdist(m_vwa, m_ra));
        chk("R4 empty", empty, m_empty);
        chk("R5 rd_go", rd_go, exp_go());
        chk("R6 ovf_state", ovf_state, m_ovs);
        chk("R7 ovf_once", ovf_once, m_ovo);
        chk("R10 mute_req", mute_req, sys_on && m_empty);
    endtask

    task automatic idle_inputs();
        wr_adv = 0; rd_adv = 0; wa_clr = 0; ra_clr = 0;
        commit = 0; wr_stop = 0; stat_rd = 0;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        idle_inputs();
    endtask

    task automatic do_reset(input logic [1:0] sel);
        @(negedge clk);
        rst_n = 0; mem_sel = sel; idle_inputs(); blk_clk = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_wa = 0; m_ra = 0; m_vwa = 0; m_cand = 0;
        m_blk = 0; m_empty = 0; m_ovs = 0; m_ovo = 0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 residual", residual, 0);
        chk("R1 empty", empty, 0);
        chk("R1 ovf_state", ovf_state, 0);
        chk("R1 ovf_once", ovf_once, 0);
        chk("R1 mute_req", mute_req, 0);
    endtask

    task automatic writes(input int n);
        for (int i = 0; i < n; i++) begin
            wr_adv = 1;
            tick();
        end
    endtask

    task automatic rand_run(input int n, input int pw, input int pr, input int pc);
        for (int i = 0; i < n; i++) begin
            wr_adv  = ($urandom % 100) < pw;
            rd_adv  = ($urandom % 100) < pr;
            commit  = ($urandom % 100) < pc;
            stat_rd = ($urandom % 100) < 3;
            wr_stop = ($urandom % 100) < 1;
            wa_clr  = ($urandom % 1000) < 2;
            ra_clr  = ($urandom % 1000) < 2;
            if (($urandom % 100) < 10) blk_clk = ~blk_clk;
            if (($urandom % 100) < 2)  sys_on = ~sys_on;
            if (($urandom % 100) < 2)  rd_en = ~rd_en;
            tick();
        end
    endtask

    task automatic overflow_run(input logic [1:0] sel, input bit read_same);
        int unsigned lim;
        do_reset(sel);
        sys_on = 1; rd_en = 0;
        lim = span(sel) - guard(sel);
        writes(int'(lim) - 1);
        chk("R8 ovf_state before crossing", ovf_state, 0);
        wr_adv = 1; stat_rd = read_same;
        tick();
        chk("R8 ovf_state at crossing", ovf_state, 1);
        if (read_same) chk("R9 ovf_once read in crossing cycle", ovf_once, 0);
        else           chk("R8 ovf_once at crossing", ovf_once, 1);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset(2'd0);

        // R2 candidate latch and commit
        sys_on = 1; rd_en = 0;
        writes(10);
        blk_clk = 1; tick();
        blk_clk = 0; wr_adv = 1; tick();
        writes(5);
        chk("R4 empty not set by reset", empty, 0);
        commit = 1; tick();
        chk("R2 residual after commit", residual, 10);

        // R5 drain then pause
        rd_en = 1;
        for (int i = 0; i < 10; i++) begin rd_adv = 1; tick(); end
        chk("R4 empty after drain", empty, 1);
        chk("R10 mute while empty", mute_req, 1);
        chk("R5 rd_go paused", rd_go, 0);
        rd_adv = 1; tick();
        chk("R5 ignored read keeps residual", residual, 0);

        // R5 resume on new commit
        blk_clk = 1; tick();
        blk_clk = 0; tick();
        commit = 1; tick();
        chk("R5 resume residual", residual, 6);
        chk("R5 resume rd_go", rd_go, 1);
        chk("R4 empty cleared", empty, 0);

        // R11 clears and wrap
        wa_clr = 1; tick();
        chk("R11 residual after write clear wraps", residual, 4086);
        ra_clr = 1; tick();
        chk("R11 residual after read clear", residual, 0);
        chk("R4 clear does not set empty", empty, 0);

        // R8 / R9 / R7 / R6 overflow at each size
        overflow_run(2'd0, 1'b1);
        overflow_run(2'd1, 1'b0);
        overflow_run(2'd3, 1'b0);
        stat_rd = 1; tick();
        chk("R7 once cleared, state held", ovf_once, 0);
        chk("R7 state persists", ovf_state, 1);
        wr_stop = 1; tick();
        chk("R6 state cleared by stop", ovf_state, 0);

        // random mix
        do_reset(2'd0);
        sys_on = 1; rd_en = 1;
        rand_run(8000, 60, 50, 4);
        do_reset(2'd2);
        rand_run(4000, 90, 20, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule